// File: doc/BRIEF.md
# Multi-Mode Conversion Sequencer

This block runs the conversions of an eight-channel analog-to-digital converter according to a small control word. Software writes a channel number, a 2-bit mode, a start bit and a stall enable in one write. The block then issues per-channel requests to the converter, stores each result with the channel it came from in a data register, and raises a one-cycle completion request for every stored result. It raises an overrun request when a stored result was never read. The converter itself is a behavioural stub with a fixed, parameterised latency, so result timing is fully predictable.

A write that arrives while a sequence is running is not applied at once. The mode is applied when the running conversion ends. The channel number and a new start are applied at the end of the sequence: after the current conversion in fixed-channel modes, and only after channel 0 has been converted in scan modes. When the stall enable is set, a second finished result is held back and the sequencer stops until the data register is read, so no result is ever lost.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Mode 2'b00 (fixed, single) converts the programmed channel once and then goes idle; bit 1 of the mode selects scanning and bit 0 selects repetition.
- R2: Mode 2'b01 (fixed, continuous) converts the programmed channel again and again, with no idle cycle between conversions.
- R3: A scan started at channel n converts n, n-1, down to 0; mode 2'b10 then goes idle and mode 2'b11 restarts at n.
- R4: A start written while idle gives its first result and completion request LAT clock edges after the edge that takes the write (LAT defaults to 4). The result value is (channel*97+13) mod 1024, and it is tagged with its 3-bit channel.
- R5: `busy` is 1 from the edge that starts a sequence until the edge that stores the sequence's last result, and it stays 1 while a result is held back.
- R6: A mode written during a conversion takes effect when that conversion ends.
- R7: A channel number or start written during a conversion takes effect after that conversion in fixed modes, and only after channel 0 in scan modes.
- R8: A write with the start bit at 0 while idle starts nothing: `busy` and the completion request stay 0.
- R9: Every stored result pulses `cmp_req` for one cycle. A `data_rd` pulse marks the stored result as read.
- R10: Storing a result while the previous one is unread (and not being read in the same cycle) pulses `ovr_req` together with `cmp_req`.
- R11: With the stall enable set, a result that finishes while the previous one is unread is held. The data register, `cmp_req` and `ovr_req` stay unchanged, and no further conversion starts, until `data_rd`. The held result is stored on the edge that takes the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_ch | input | 3 | Channel number (scan start channel) |
| cfg_mode | input | 2 | Mode: bit 1 scan, bit 0 continuous |
| cfg_start | input | 1 | Start request |
| cfg_wait | input | 1 | Stall-until-read enable |
| data_rd | input | 1 | Data register read strobe |
| data_res | output | 10 | Stored conversion result |
| data_ch | output | 3 | Channel of the stored result |
| busy | output | 1 | Sequence in progress |
| cmp_req | output | 1 | Completion request pulse |
| ovr_req | output | 1 | Overrun request pulse |

## Verification
The assertions check several rules on every cycle. The converter is never active while the block reports idle. A write without start while idle never makes the block busy. An overrun never appears without a completion. A completion only follows a converter finish or a read. A held result keeps the data register frozen until it is read. Only the bench scenarios can show the channel orderings, the exact latency, and the deferral points of mode, channel and start writes made mid-conversion or mid-scan. They also show the difference between a plain overrun and a stall under the enable.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    MD_FIX_ONE  = 2'b00,
    MD_FIX_LOOP = 2'b01,
    MD_SCN_ONE  = 2'b10,
    MD_SCN_LOOP = 2'b11
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_CONV = 2'b01,
    ST_HOLD = 2'b10
  } seq_st_e;
endpackage

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
  parameter int LAT   = 4,
  parameter int CH_W  = 3,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CH_W-1:0]  go_ch,
  output logic             done,
  output logic             active,
  output logic [RES_W-1:0] res,
  output logic [CH_W-1:0]  res_ch
);
  localparam int CNT_W = $clog2(LAT + 1);
  localparam int RES_MOD = 1 << RES_W;

  logic             run_q, run_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CH_W-1:0]  ch_q, ch_n;

  always_comb begin
    run_n = run_q;
    cnt_n = cnt_q;
    ch_n  = ch_q;
    done  = run_q && (cnt_q == '0);
    if (go) begin
      run_n = 1'b1;
      cnt_n = CNT_W'(LAT - 1);
      ch_n  = go_ch;
    end else if (done) begin
      run_n = 1'b0;
    end else if (run_q) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      ch_q  <= '0;
    end else begin
      run_q <= run_n;
      cnt_q <= cnt_n;
      ch_q  <= ch_n;
    end
  end

  // Deterministic code so results are predictable per channel.
  always_comb begin
    int v;
    v      = (int'(ch_q) * 97 + 13) % RES_MOD;
    res    = RES_W'(v);
    res_ch = ch_q;
    active = run_q;
  end
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int CH_W  = 3,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_now,
  input  logic             cap,
  input  logic             rel,
  input  logic             rd,
  input  logic [RES_W-1:0] in_res,
  input  logic [CH_W-1:0]  in_ch,
  output logic [RES_W-1:0] data_res,
  output logic [CH_W-1:0]  data_ch,
  output logic             unread,
  output logic             cmp_req,
  output logic             ovr_req
);
  logic [RES_W-1:0] hold_res_q, res_q, res_n;
  logic [CH_W-1:0]  hold_ch_q, ch_q, ch_n;
  logic             unread_q, unread_n, cmp_n, ovr_n, cmp_q, ovr_q, wr;

  always_comb begin
    wr       = wr_now || rel;
    res_n    = rel ? hold_res_q : in_res;
    ch_n     = rel ? hold_ch_q  : in_ch;
    unread_n = wr ? 1'b1 : (rd ? 1'b0 : unread_q);
    cmp_n    = wr;
    ovr_n    = wr && unread_q && !rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q      <= '0;
      ch_q       <= '0;
      hold_res_q <= '0;
      hold_ch_q  <= '0;
      unread_q   <= 1'b0;
      cmp_q      <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      if (wr) begin
        res_q <= res_n;
        ch_q  <= ch_n;
      end
      if (cap) begin
        hold_res_q <= in_res;
        hold_ch_q  <= in_ch;
      end
      unread_q <= unread_n;
      cmp_q    <= cmp_n;
      ovr_q    <= ovr_n;
    end
  end

  assign data_res = res_q;
  assign data_ch  = ch_q;
  assign unread   = unread_q;
  assign cmp_req  = cmp_q;
  assign ovr_req  = ovr_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CH_W-1:0] cfg_ch,
  input  seq_mode_e       cfg_mode,
  input  logic            cfg_start,
  input  logic            cfg_wait,
  input  logic            done,
  input  logic            unread,
  input  logic            rd,
  output logic            go,
  output logic [CH_W-1:0] go_ch,
  output logic            wr_now,
  output logic            cap,
  output logic            rel,
  output logic            busy,
  output logic            hold
);
  seq_st_e         st_q, st_n;
  seq_mode_e       act_mode_q, act_mode_n, pend_mode_q, pend_mode_n;
  logic            act_wait_q, act_wait_n, pend_wait_q, pend_wait_n;
  logic [CH_W-1:0] cur_ch_q, cur_ch_n, pend_ch_q, pend_ch_n;
  logic            start_pend_q, start_pend_n;
  logic            stall, finish, seq_end;

  always_comb begin
    stall   = (st_q == ST_CONV) && done && act_wait_q && unread && !rd;
    wr_now  = (st_q == ST_CONV) && done && !stall;
    rel     = (st_q == ST_HOLD) && rd;
    cap     = stall;
    finish  = wr_now || rel;
    // Sequence ends after a fixed conversion, after channel 0, or when scanning is switched off.
    seq_end = !act_mode_q[1] || (cur_ch_q == '0) || !pend_mode_q[1];

    st_n         = st_q;
    act_mode_n   = act_mode_q;
    act_wait_n   = act_wait_q;
    pend_mode_n  = pend_mode_q;
    pend_wait_n  = pend_wait_q;
    pend_ch_n    = pend_ch_q;
    start_pend_n = start_pend_q;
    cur_ch_n     = cur_ch_q;
    go           = 1'b0;
    go_ch        = cur_ch_q;

    if (cfg_we) begin
      pend_ch_n   = cfg_ch;
      pend_mode_n = cfg_mode;
      pend_wait_n = cfg_wait;
      if (cfg_start && (st_q != ST_IDLE)) start_pend_n = 1'b1;
    end

    case (st_q)
      ST_IDLE: begin
        if (cfg_we) begin
          act_mode_n = cfg_mode;
          act_wait_n = cfg_wait;
          if (cfg_start) begin
            go    = 1'b1;
            go_ch = cfg_ch;
            st_n  = ST_CONV;
          end
        end
      end
      ST_CONV: if (stall) st_n = ST_HOLD;
      default: ;
    endcase

    if (finish) begin
      act_mode_n = pend_mode_q;
      act_wait_n = pend_wait_q;
      if (seq_end) begin
        start_pend_n = cfg_we && cfg_start;
        if (start_pend_q || pend_mode_q[0]) begin
          go    = 1'b1;
          go_ch = pend_ch_q;
          st_n  = ST_CONV;
        end else begin
          st_n = ST_IDLE;
        end
      end else begin
        go    = 1'b1;
        go_ch = cur_ch_q - 1'b1;
        st_n  = ST_CONV;
      end
    end

    if (go) cur_ch_n = go_ch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      act_mode_q   <= MD_FIX_ONE;
      pend_mode_q  <= MD_FIX_ONE;
      act_wait_q   <= 1'b0;
      pend_wait_q  <= 1'b0;
      cur_ch_q     <= '0;
      pend_ch_q    <= '0;
      start_pend_q <= 1'b0;
    end else begin
      st_q         <= st_n;
      act_mode_q   <= act_mode_n;
      pend_mode_q  <= pend_mode_n;
      act_wait_q   <= act_wait_n;
      pend_wait_q  <= pend_wait_n;
      cur_ch_q     <= cur_ch_n;
      pend_ch_q    <= pend_ch_n;
      start_pend_q <= start_pend_n;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign hold = (st_q == ST_HOLD);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int LAT    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(NUM_CH)-1:0] cfg_ch,
  input  logic [1:0]                cfg_mode,
  input  logic                      cfg_start,
  input  logic                      cfg_wait,
  input  logic                      data_rd,
  output logic [RES_W-1:0]          data_res,
  output logic [$clog2(NUM_CH)-1:0] data_ch,
  output logic                      busy,
  output logic                      cmp_req,
  output logic                      ovr_req
);
  localparam int CH_W = $clog2(NUM_CH);

  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             stub_go, stub_done, stub_active;
  logic [CH_W-1:0]  stub_go_ch, stub_ch;
  logic [RES_W-1:0] stub_res;
  logic             wr_now, cap, rel, unread, seq_hold;

  adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
    .clk(clk), .rst_n(rst_sync_q),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_mode(seq_mode_e'(cfg_mode)),
    .cfg_start(cfg_start), .cfg_wait(cfg_wait),
    .done(stub_done), .unread(unread), .rd(data_rd),
    .go(stub_go), .go_ch(stub_go_ch),
    .wr_now(wr_now), .cap(cap), .rel(rel),
    .busy(busy), .hold(seq_hold)
  );

  adc_conv_stub #(.LAT(LAT), .CH_W(CH_W), .RES_W(RES_W)) u_stub (
    .clk(clk), .rst_n(rst_sync_q),
    .go(stub_go), .go_ch(stub_go_ch),
    .done(stub_done), .active(stub_active),
    .res(stub_res), .res_ch(stub_ch)
  );

  adc_result_reg #(.CH_W(CH_W), .RES_W(RES_W)) u_res (
    .clk(clk), .rst_n(rst_sync_q),
    .wr_now(wr_now), .cap(cap), .rel(rel), .rd(data_rd),
    .in_res(stub_res), .in_ch(stub_ch),
    .data_res(data_res), .data_ch(data_ch), .unread(unread),
    .cmp_req(cmp_req), .ovr_req(ovr_req)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             cfg_start,
  input logic             data_rd,
  input logic [RES_W-1:0] data_res,
  input logic             busy,
  input logic             cmp_req,
  input logic             ovr_req,
  input logic             stub_active,
  input logic             stub_done,
  input logic             seq_hold
);
  assert_stub_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stub_active |-> busy);

  assert_idle_nostart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cfg_we && !cfg_start) |=> !busy);

  assert_ovr_with_cmp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_req |-> cmp_req);

  assert_cmp_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req |-> $past(stub_done || data_rd));

  assert_hold_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_hold && !data_rd) |=> ($stable(data_res) && !cmp_req && !ovr_req));
endmodule

bind adc_seq_ctrl adc_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_q),
  .cfg_we(cfg_we), .cfg_start(cfg_start), .data_rd(data_rd),
  .data_res(data_res), .busy(busy), .cmp_req(cmp_req), .ovr_req(ovr_req),
  .stub_active(stub_active), .stub_done(stub_done), .seq_hold(seq_hold)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int LAT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, cfg_start = 1'b0, cfg_wait = 1'b0, data_rd = 1'b0;
  logic [2:0] cfg_ch = '0;
  logic [1:0] cfg_mode = '0;
  logic [9:0] data_res;
  logic [2:0] data_ch;
  logic       busy, cmp_req, ovr_req;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl #(.NUM_CH(8), .RES_W(10), .LAT(LAT)) u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_mode(cfg_mode),
    .cfg_start(cfg_start), .cfg_wait(cfg_wait), .data_rd(data_rd),
    .data_res(data_res), .data_ch(data_ch), .busy(busy),
    .cmp_req(cmp_req), .ovr_req(ovr_req)
  );

  // Vector table: {channel, mode}; modes 00 and 10 only.
  localparam logic [4:0] VEC [0:7] = '{
    {3'd0, 2'b00}, {3'd7, 2'b00}, {3'd4, 2'b00}, {3'd2, 2'b10},
    {3'd5, 2'b10}, {3'd0, 2'b10}, {3'd7, 2'b10}, {3'd1, 2'b00}
  };

  function automatic int exp_code(input int c);
    return (c * 97 + 13) % 1024;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_cfg(input int ch, input int md, input bit st, input bit wt);
    cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_mode = 2'(md); cfg_start = st; cfg_wait = wt;
    @(negedge clk);
    cfg_we = 1'b0; cfg_start = 1'b0;
  endtask

  task automatic rd_pulse();
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
  endtask

  task automatic wait_cmp(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cmp_req && n < 200);
  endtask

  // Expects a result on channel c, checks it, then reads it.
  task automatic take(input int c, input string req, input bit exp_ovr);
    int n;
    wait_cmp(n);
    chk(cmp_req === 1'b1, req, int'(cmp_req), 1);
    chk(data_ch == 3'(c) && data_res == 10'(exp_code(c)), req, int'(data_ch), c);
    chk(ovr_req === exp_ovr, {req, " ovr"}, int'(ovr_req), int'(exp_ovr));
    rd_pulse();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    cyc(3);
    // Reset state
    chk(!busy && !cmp_req && !ovr_req && data_res == '0, "R5 reset", int'(busy), 0);
    rst_n = 1'b1;
    cyc(4);

    // Table walk: R1 fixed single and R3 scan single, R4 latency and code
    for (int v = 0; v < 8; v++) begin
      int c;
      int md;
      c  = int'(VEC[v][4:2]);
      md = int'(VEC[v][1:0]);
      wr_cfg(c, md, 1'b1, 1'b0);
      chk(busy === 1'b1, "R5 busy after start", int'(busy), 1);
      wait_cmp(n);
      chk(n == LAT, "R4 latency", n, LAT);
      forever begin
        chk(data_ch == 3'(c) && data_res == 10'(exp_code(c)),
            md[1] ? "R3 scan order" : "R1 fixed single", int'(data_ch), c);
        chk(ovr_req === 1'b0, "R10 no overrun when read", int'(ovr_req), 0);
        if (!md[1] || c == 0) break;
        rd_pulse();
        c--;
        wait_cmp(n);
      end
      chk(busy === 1'b0, "R5 idle after last result", int'(busy), 0);
      rd_pulse();
      cyc(LAT + 2);
      chk(cmp_req === 1'b0 && busy === 1'b0, "R1 R3 stays idle", int'(busy), 0);
    end

    // R8: mode write while idle without start
    wr_cfg(4, 3, 1'b0, 1'b0);
    begin
      bit seen;
      seen = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (busy || cmp_req) seen = 1'b1;
      end
      chk(!seen, "R8 no conversion without start", int'(seen), 0);
    end

    // R2 + R10: fixed continuous, no reads -> overrun
    wr_cfg(5, 1, 1'b1, 1'b0);
    wait_cmp(n);
    chk(ovr_req === 1'b0 && data_ch == 3'd5, "R2 first result", int'(ovr_req), 0);
    wait_cmp(n);
    chk(n == LAT, "R2 back-to-back", n, LAT);
    chk(ovr_req === 1'b1, "R10 overrun on unread", int'(ovr_req), 1);
    wr_cfg(5, 0, 1'b0, 1'b0);            // R6 mode change mid conversion
    wait_cmp(n);
    chk(ovr_req === 1'b1 && data_ch == 3'd5, "R10 overrun again", int'(ovr_req), 1);
    chk(busy === 1'b0, "R6 stop after current conversion", int'(busy), 0);
    rd_pulse();
    cyc(LAT + 2);
    chk(busy === 1'b0 && cmp_req === 1'b0, "R6 remains idle", int'(busy), 0);

    // R11: stall until read
    wr_cfg(3, 1, 1'b1, 1'b1);
    wait_cmp(n);
    chk(ovr_req === 1'b0, "R11 first result", int'(ovr_req), 0);
    begin
      bit seen;
      seen = 1'b0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (cmp_req || ovr_req || !busy) seen = 1'b1;
      end
      chk(!seen, "R11 held while unread", int'(seen), 0);
      chk(data_ch == 3'd3 && data_res == 10'(exp_code(3)), "R11 data frozen", int'(data_res), exp_code(3));
    end
    rd_pulse();
    chk(cmp_req === 1'b1 && ovr_req === 1'b0, "R11 release on read", int'(cmp_req), 1);
    wr_cfg(3, 0, 1'b0, 1'b1);
    rd_pulse();
    wait_cmp(n);
    chk(cmp_req === 1'b1 && ovr_req === 1'b0 && busy === 1'b0, "R11 R9 last result", int'(busy), 0);
    rd_pulse();
    cyc(3);

    // R7 fixed: channel change takes effect after current conversion
    wr_cfg(1, 1, 1'b1, 1'b0);
    take(1, "R7 fixed first", 1'b0);
    wr_cfg(6, 1, 1'b1, 1'b0);
    take(1, "R7 fixed current kept", 1'b0);
    take(6, "R7 fixed new channel", 1'b0);
    wr_cfg(6, 0, 1'b0, 1'b0);
    take(6, "R7 fixed stop", 1'b0);
    chk(busy === 1'b0, "R7 idle", int'(busy), 0);
    cyc(3);

    // R7 scan: new channel/start only after channel 0
    wr_cfg(3, 2, 1'b1, 1'b0);
    wr_cfg(5, 2, 1'b1, 1'b0);
    for (int c = 3; c >= 0; c--) take(c, "R7 scan finishes old sequence", 1'b0);
    for (int c = 5; c >= 0; c--) take(c, "R7 scan new sequence", 1'b0);
    cyc(2);
    chk(busy === 1'b0, "R7 scan idle", int'(busy), 0);

    // R6 + R3: continuous scan switched to single mid-scan
    wr_cfg(2, 3, 1'b1, 1'b0);
    wr_cfg(2, 2, 1'b0, 1'b0);
    for (int c = 2; c >= 0; c--) take(c, "R6 scan", 1'b0);
    cyc(LAT + 2);
    chk(busy === 1'b0 && cmp_req === 1'b0, "R6 single scan ends at 0", int'(busy), 0);

    // R3: continuous scan restarts at n
    wr_cfg(1, 3, 1'b1, 1'b0);
    take(1, "R3 loop", 1'b0);
    take(0, "R3 loop", 1'b0);
    wr_cfg(1, 2, 1'b0, 1'b0);
    take(1, "R3 loop restart", 1'b0);
    take(0, "R3 loop end", 1'b0);
    cyc(2);
    chk(busy === 1'b0, "R3 idle", int'(busy), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule